// File: doc/BRIEF.md
# Load/Store Unit with Fixed Address Map

This unit sits in the memory stage of a 32-bit integer core. For each request it takes a byte address, the store data, an access size and a flag that selects signed or unsigned loads. For stores it produces a four-bit byte-lane mask and write data placed on the correct lanes of a word-wide data RAM. For loads it selects the addressed byte or halfword from the fetched word and extends it to 32 bits.

The address space has three parts. A flat RAM region starts at address zero. A four-bit output register sits at one fixed I/O word. A completion mailbox sits at a second I/O word, and a test harness watches it. Stores to either I/O word never reach the RAM. Misaligned addresses do not trap: the low address bits that the access size does not use are ignored.

RAM writes and register updates take effect at the clock edge. Load data, the lane mask and the aligned write data are combinational from the request.

Top module: `lsu_mem_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `led_out` = 0, `done_valid` = 0 and `done_value` = 0.
- R2: A byte store (`req_size` = 0) to RAM enables exactly the one lane selected by `addr[1:0]` (mask bit n for lane n, that is bits 8n+7:8n). It drives the store byte onto all four lanes of `ram_wdata`.
- R3: A halfword store (`req_size` = 1) enables lanes 3:2 when `addr[1]` = 1 and lanes 1:0 otherwise; `addr[0]` is ignored. The halfword is copied into both halves of `ram_wdata`. A word store (`req_size` = 2 or 3) enables all four lanes whatever `addr[1:0]` is.
- R4: Loads select the byte at `addr[1:0]` or the halfword at `addr[1]`. They sign-extend when `req_unsigned` = 0 and zero-extend when `req_unsigned` = 1. Word loads return the whole word.
- R5: Addresses below `RAM_BYTES` (default 1024) map to RAM word `addr[log2(RAM_BYTES)-1:2]`. A store becomes visible to loads in the cycle after it. Lanes that the store did not enable keep their old contents.
- R6: A store to the word at 0x8000_0000 that enables lane 0 loads bits 3:0 of the lane-aligned data into `led_out` at the next edge. A store to that word that leaves lane 0 disabled leaves `led_out` unchanged. Loads from that word return `{28'b0, led_out}`.
- R7: A store to the word at 0x8000_1000 sets `done_valid` and captures the raw `req_wdata` into `done_value` at the next edge. `done_valid` stays at 1 until reset, and a later store to the mailbox replaces `done_value`.
- R8: Stores to the I/O words or to unmapped addresses drive `ram_be` to 0 and leave RAM contents unchanged. Loads from the mailbox or from unmapped addresses return 0.
- R9: When `req_valid` = 0, `ram_be` is 0, and RAM, `led_out` and the mailbox do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend sub-word loads |
| req_wdata | input | 32 | Store data, right-aligned |
| load_data | output | 32 | Extended load result (combinational) |
| ram_be | output | 4 | Byte-lane enables applied to the RAM |
| ram_wdata | output | 32 | Lane-aligned store data |
| led_out | output | 4 | Output register |
| done_valid | output | 1 | Mailbox has been written |
| done_value | output | 32 | Last value stored to the mailbox |

## Verification
`load_data`, `ram_be` and `ram_wdata` are due in the same cycle as the request. The bench samples them one nanosecond after it drives the inputs on the falling edge. `led_out`, `done_valid`, `done_value` and RAM contents change at the rising edge that follows the request, so those expectations go into a second queue and are compared at the next falling-edge sample. A load that checks the effect of a store is always issued in a later cycle than the store, so it reads the RAM after the write edge.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam logic [31:0] LED_ADDR  = 32'h8000_0000;
    localparam logic [31:0] MBOX_ADDR = 32'h8000_1000;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RGN_RAM,
        RGN_LED,
        RGN_MBOX,
        RGN_NONE
    } region_e;

    typedef struct packed {
        logic [3:0]  be;
        logic [31:0] data;
    } lane_wr_t;

    function automatic logic [3:0] lane_mask(acc_size_e sz, logic [1:0] off);
        case (sz)
            SZ_BYTE: return 4'b0001 << off;
            SZ_HALF: return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic same_word(logic [31:0] a, logic [31:0] b);
        return a[31:2] == b[31:2];
    endfunction

endpackage

// File: rtl/lsu_region_decode.sv
module lsu_region_decode
    import lsu_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic [31:0] addr,
    output region_e     region
);
    always_comb begin
        if (addr[31:RAM_AW] == '0)
            region = RGN_RAM;
        else if (same_word(addr, LED_ADDR))
            region = RGN_LED;
        else if (same_word(addr, MBOX_ADDR))
            region = RGN_MBOX;
        else
            region = RGN_NONE;
    end
endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align
    import lsu_pkg::*;
(
    input  acc_size_e   sz,
    input  logic [1:0]  off,
    input  logic [31:0] wdata,
    output lane_wr_t    lanes
);
    always_comb begin
        lanes.be = lane_mask(sz, off);
        case (sz)
            SZ_BYTE: lanes.data = {4{wdata[7:0]}};
            SZ_HALF: lanes.data = {2{wdata[15:0]}};
            default: lanes.data = wdata;
        endcase
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  acc_size_e   sz,
    input  logic [1:0]  off,
    input  logic        uns,
    input  logic [31:0] word,
    output logic [31:0] data
);
    logic [31:0] shifted;
    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    always_comb begin
        shifted  = word >> {off, 3'b000};
        sel_byte = shifted[7:0];
        sel_half = off[1] ? word[31:16] : word[15:0];
        case (sz)
            SZ_BYTE: data = {{24{~uns & sel_byte[7]}}, sel_byte};
            SZ_HALF: data = {{16{~uns & sel_half[15]}}, sel_half};
            default: data = word;
        endcase
    end
endmodule

// File: rtl/lsu_mem_unit.sv
module lsu_mem_unit
    import lsu_pkg::*;
#(
    parameter int RAM_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic        req_unsigned,
    input  logic [31:0] req_wdata,
    output logic [31:0] load_data,
    output logic [3:0]  ram_be,
    output logic [31:0] ram_wdata,
    output logic [3:0]  led_out,
    output logic        done_valid,
    output logic [31:0] done_value
);
    localparam int RAM_AW = $clog2(RAM_BYTES);
    localparam int DEPTH  = RAM_BYTES / 4;
    localparam int IDX_W  = RAM_AW - 2;

    acc_size_e          sz;
    region_e            region;
    lane_wr_t           lanes;
    logic               write_en;
    logic [IDX_W-1:0]   ram_idx;
    logic [31:0]        read_word;
    logic [31:0]        mem [DEPTH];

    assign sz       = acc_size_e'(req_size);
    assign write_en = req_valid && req_write;
    assign ram_idx  = req_addr[RAM_AW-1:2];

    lsu_region_decode #(.RAM_AW(RAM_AW)) u_decode (
        .addr   (req_addr),
        .region (region)
    );

    lsu_store_align u_align (
        .sz    (sz),
        .off   (req_addr[1:0]),
        .wdata (req_wdata),
        .lanes (lanes)
    );

    assign ram_be    = (write_en && region == RGN_RAM) ? lanes.be : 4'b0000;
    assign ram_wdata = lanes.data;

    always_ff @(posedge clk) begin
        for (int l = 0; l < 4; l++) begin
            if (ram_be[l])
                mem[ram_idx][8*l +: 8] <= lanes.data[8*l +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led_out    <= 4'h0;
            done_valid <= 1'b0;
            done_value <= 32'h0;
        end else begin
            if (write_en && region == RGN_LED && lanes.be[0])
                led_out <= lanes.data[3:0];
            if (write_en && region == RGN_MBOX) begin
                done_valid <= 1'b1;
                done_value <= req_wdata;
            end
        end
    end

    always_comb begin
        case (region)
            RGN_RAM: read_word = mem[ram_idx];
            RGN_LED: read_word = {28'h0, led_out};
            default: read_word = 32'h0;
        endcase
    end

    lsu_load_extract u_extract (
        .sz   (sz),
        .off  (req_addr[1:0]),
        .uns  (req_unsigned),
        .word (read_word),
        .data (load_data)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (led_out == 4'h0 && !done_valid && done_value == 32'h0)); // R1

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size == 2'd0 && req_addr[31:RAM_AW] == '0)
        |-> $countones(ram_be) == 1); // R2

    AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size[1] && req_addr[31:RAM_AW] == '0)
        |-> ram_be == 4'hF); // R3

    AST_UNSIGNED_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'd0 && req_unsigned)
        |-> load_data[31:8] == 24'h0); // R4

    AST_LED_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == LED_ADDR)
        |=> led_out == $past(req_wdata[3:0])); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> done_valid); // R7

    AST_IO_NO_RAM: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write &&
         (req_addr[31:2] == LED_ADDR[31:2] || req_addr[31:2] == MBOX_ADDR[31:2]))
        |-> ram_be == 4'h0); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> ram_be == 4'h0); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(led_out) && $stable(done_value))); // R9

endmodule

// File: tb/lsu_mem_unit_bench.sv
`timescale 1ns/1ps
module lsu_mem_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic [1:0]  req_size = 2'd2;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_wdata = 32'h0;
    logic [31:0] load_data;
    logic [3:0]  ram_be;
    logic [31:0] ram_wdata;
    logic [3:0]  led_out;
    logic        done_valid;
    logic [31:0] done_value;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lsu_mem_unit u_lsu_mem_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_unsigned(req_unsigned),
        .req_wdata(req_wdata), .load_data(load_data), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .led_out(led_out), .done_valid(done_valid),
        .done_value(done_value)
    );

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
    } exp_t;

    exp_t q_now[$];
    exp_t q_stage[$];
    exp_t q_ready[$];

    function automatic logic [31:0] observe(int kind);
        case (kind)
            0: return load_data;
            1: return {28'h0, led_out};
            2: return {31'h0, done_valid};
            3: return done_value;
            4: return {28'h0, ram_be};
            default: return ram_wdata;
        endcase
    endfunction

    task automatic compare(exp_t e);
        logic [31:0] act;
        act = observe(e.kind);
        checks++;
        if (act !== e.exp) begin
            failures++;
            $display("FAIL %s kind=%0d actual=%08h expected=%08h", e.tag, e.kind, act, e.exp);
        end
    endtask

    task automatic exp_now(string tag, int kind, logic [31:0] v);
        exp_t e;
        e.tag = tag; e.kind = kind; e.exp = v;
        q_now.push_back(e);
    endtask

    task automatic exp_next(string tag, int kind, logic [31:0] v);
        exp_t e;
        e.tag = tag; e.kind = kind; e.exp = v;
        q_stage.push_back(e);
    endtask

    task automatic drive(bit v, bit w, logic [31:0] a, logic [1:0] s, bit u, logic [31:0] d);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a;
        req_size = s; req_unsigned = u; req_wdata = d;
    endtask

    // Monitor: sequential items pushed one cycle ago, then combinational items of this cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_ready.size() > 0) compare(q_ready.pop_front());
            while (q_stage.size() > 0) q_ready.push_back(q_stage.pop_front());
            while (q_now.size() > 0) compare(q_now.pop_front());
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_now("R1 led reset", 1, 32'h0);
        exp_now("R1 done_valid reset", 2, 32'h0);
        exp_now("R1 done_value reset", 3, 32'h0);

        drive(1, 1, 32'h10, 2'd2, 0, 32'h1122_3344);
        exp_now("R3 word mask", 4, 32'hF);
        exp_now("R3 word data", 5, 32'h1122_3344);
        drive(1, 0, 32'h10, 2'd2, 0, 32'h0);
        exp_now("R5 word readback", 0, 32'h1122_3344);

        drive(1, 1, 32'h11, 2'd0, 0, 32'h0000_00A5);
        exp_now("R2 byte mask", 4, 32'h2);
        exp_now("R2 byte replicate", 5, 32'hA5A5_A5A5);
        drive(1, 0, 32'h10, 2'd2, 0, 32'h0);
        exp_now("R5 other lanes kept", 0, 32'h1122_A544);

        drive(1, 0, 32'h11, 2'd0, 0, 32'h0);
        exp_now("R4 LB sign", 0, 32'hFFFF_FFA5);
        drive(1, 0, 32'h11, 2'd0, 1, 32'h0);
        exp_now("R4 LBU zero", 0, 32'h0000_00A5);
        drive(1, 0, 32'h13, 2'd0, 0, 32'h0);
        exp_now("R4 LB lane3", 0, 32'h0000_0011);

        drive(1, 1, 32'h13, 2'd1, 0, 32'h0000_8001);
        exp_now("R3 half mask addr0 ignored", 4, 32'hC);
        exp_now("R3 half replicate", 5, 32'h8001_8001);
        drive(1, 0, 32'h12, 2'd1, 0, 32'h0);
        exp_now("R4 LH sign", 0, 32'hFFFF_8001);
        drive(1, 0, 32'h12, 2'd1, 1, 32'h0);
        exp_now("R4 LHU zero", 0, 32'h0000_8001);
        drive(1, 0, 32'h10, 2'd2, 0, 32'h0);
        exp_now("R5 half merged", 0, 32'h8001_A544);

        drive(1, 1, 32'h23, 2'd2, 0, 32'hDEAD_BEEF);
        exp_now("R3 misaligned word mask", 4, 32'hF);
        drive(1, 0, 32'h20, 2'd2, 0, 32'h0);
        exp_now("R5 misaligned word stored", 0, 32'hDEAD_BEEF);
        drive(1, 0, 32'h23, 2'd0, 0, 32'h0);
        exp_now("R4 LB top lane", 0, 32'hFFFF_FFDE);

        drive(1, 1, 32'h8000_0000, 2'd2, 0, 32'h0000_000B);
        exp_now("R8 led write no ram", 4, 32'h0);
        exp_next("R6 led updated", 1, 32'hB);
        drive(1, 0, 32'h8000_0000, 2'd2, 0, 32'h0);
        exp_now("R6 led readback", 0, 32'h0000_000B);
        drive(1, 1, 32'h8000_0001, 2'd0, 0, 32'h0000_000F);
        exp_next("R6 lane1 store ignored", 1, 32'hB);

        drive(1, 1, 32'h8000_1000, 2'd2, 0, 32'hCAFE_0001);
        exp_now("R8 mailbox no ram", 4, 32'h0);
        exp_next("R7 done set", 2, 32'h1);
        exp_next("R7 done value", 3, 32'hCAFE_0001);
        drive(1, 0, 32'h8000_1000, 2'd2, 0, 32'h0);
        exp_now("R8 mailbox reads zero", 0, 32'h0);

        drive(1, 1, 32'h4000_0010, 2'd2, 0, 32'h0);
        exp_now("R8 unmapped no ram", 4, 32'h0);
        drive(1, 0, 32'h10, 2'd2, 0, 32'h0);
        exp_now("R8 ram untouched by alias", 0, 32'h8001_A544);
        drive(1, 0, 32'h4000_0010, 2'd2, 0, 32'h0);
        exp_now("R8 unmapped reads zero", 0, 32'h0);

        drive(0, 1, 32'h10, 2'd2, 0, 32'h0);
        exp_now("R9 idle no mask", 4, 32'h0);
        drive(0, 1, 32'h8000_0000, 2'd2, 0, 32'h3);
        exp_next("R9 idle led held", 1, 32'hB);
        drive(0, 1, 32'h8000_1000, 2'd2, 0, 32'h5);
        exp_next("R9 idle mailbox held", 3, 32'hCAFE_0001);
        drive(1, 0, 32'h10, 2'd2, 0, 32'h0);
        exp_now("R9 ram unchanged", 0, 32'h8001_A544);

        drive(1, 1, 32'h8000_1000, 2'd0, 0, 32'h0000_0077);
        exp_next("R7 done sticky", 2, 32'h1);
        exp_next("R7 value replaced", 3, 32'h0000_0077);

        drive(0, 0, 32'h0, 2'd2, 0, 32'h0);
        repeat (3) @(negedge clk);
        #2;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule